// File: doc/BRIEF.md
# Message-start sequence detector

The block monitors a one-bit serial message stream, taking one bit at every rising clock edge. It raises a flag when the stream first shows either of two start markers: two ones in a row, or the four-bit run one, zero, zero, one. Partial matches may overlap, so a one that completes one marker can also begin another. The flag marks only the first marker seen since reset. After that the detector parks in a terminal state and ignores the stream until it is reset again.

It is a Moore machine. The flag depends only on the registered state, so it is high during the clock cycle that follows the edge at which the last marker bit was sampled. A synchronous, active-high reset returns the machine to its search state from any state.

Top module: `msg_start_detect`

## Requirements
- R1: When `rst` is high at a rising edge, the machine returns to searching with no history. `detect` is 0 in the following cycle, and later bits are matched as if the stream started after that edge.
- R2: While searching, two consecutive sampled ones raise `detect` to 1 for the cycle after the edge that sampled the second one.
- R3: While searching, the sampled run 1,0,0,1 raises `detect` to 1 for the cycle after the edge that sampled the final 1.
- R4: Overlapping matches are honoured. In the stream 0,1,0,1,1 the flag rises after the fifth bit. In the stream 1,0,0,1 the final one completes the four-bit marker.
- R5: Zeros that come before any one since reset do not count toward the four-bit marker. The stream 0,0,1,0 produces no flag.
- R6: A run of three or more zeros drops any partial four-bit match. The stream 1,0,0,0,1 produces no flag by its last bit.
- R7: `detect` is high for exactly one cycle per reset period.
- R8: After the flag, `detect` stays 0 whatever `din` does, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one stream bit is sampled per edge |
| rst | input | 1 | Synchronous active-high reset to the search state |
| din | input | 1 | Serial message bit |
| detect | output | 1 | One-cycle flag marking the first start marker since reset |

## Verification
The block has no parameters, so the bench builds the one default configuration. Every state and transition of the machine is therefore within reach of short streams. Directed streams cover the overlap cases, the leading zeros, the broken partial match and the terminal state. Long random streams with frequent resets then hit the flag at many different offsets from reset, and each output is compared with a history-based model.

// File: rtl/msd_pkg.sv
package msd_pkg;
    typedef enum logic [2:0] {
        SRCH_NONE = 3'd0,  // no useful suffix
        SRCH_1    = 3'd1,  // last bit was a one
        SRCH_10   = 3'd2,  // suffix one, zero
        SRCH_100  = 3'd3,  // suffix one, zero, zero
        FOUND     = 3'd4,  // flag cycle
        PARKED    = 3'd5   // terminal, ignores input
    } msd_state_e;

    typedef struct packed {
        msd_state_e st;
    } msd_regs_t;
endpackage

// File: rtl/msd_next.sv
module msd_next
    import msd_pkg::*;
(
    input  msd_state_e cur,
    input  logic       bit_in,
    output msd_state_e nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            SRCH_NONE: nxt = bit_in ? SRCH_1 : SRCH_NONE;
            SRCH_1:    nxt = bit_in ? FOUND  : SRCH_10;
            SRCH_10:   nxt = bit_in ? SRCH_1 : SRCH_100;
            SRCH_100:  nxt = bit_in ? FOUND  : SRCH_NONE;
            FOUND:     nxt = PARKED;
            PARKED:    nxt = PARKED;
            default:   nxt = SRCH_NONE;
        endcase
    end
endmodule

// File: rtl/msd_flag.sv
module msd_flag
    import msd_pkg::*;
(
    input  msd_state_e cur,
    output logic       flag
);
    always_comb flag = (cur == FOUND);
endmodule

// File: rtl/msg_start_detect.sv
module msg_start_detect
    import msd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic detect
);
    msd_regs_t  regs_d, regs_q;
    msd_state_e step_st;

    msd_next u_next (
        .cur    (regs_q.st),
        .bit_in (din),
        .nxt    (step_st)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = step_st;
        if (rst) regs_d.st = SRCH_NONE;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    msd_flag u_flag (
        .cur  (regs_q.st),
        .flag (detect)
    );

    // R1: reset leaves the machine searching with the flag low
    p_reset_search_r1: assert property (@(posedge clk)
        rst |=> (regs_q.st == SRCH_NONE && !detect));

    // R2: a one after a one raises the flag
    p_pair_hit_r2: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == SRCH_1 && din) |=> detect);

    // R3: a one after one-zero-zero raises the flag
    p_quad_hit_r3: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == SRCH_100 && din) |=> detect);

    // R5: no history means no flag in the next cycle
    p_empty_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == SRCH_NONE) |=> !detect);

    // R7: the flag lasts one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        detect |=> !detect);

    // R8: the terminal state holds and stays quiet
    p_parked_r8: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == PARKED) |=> (regs_q.st == PARKED && !detect));
endmodule

// File: tb/msg_start_detect_test.sv
module msg_start_detect_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic detect;

    int n_checks = 0;
    int n_fail   = 0;

    // reference history
    logic [3:0] hist  = 4'b0;
    int         seen  = 0;
    logic       found = 1'b0;
    logic       exp_q = 1'b0;

    msg_start_detect uut (.clk(clk), .rst(rst), .din(din), .detect(detect));

    always #5 clk = ~clk;

    function automatic logic marker(input logic [3:0] h, input int n);
        return (n >= 2 && h[1:0] == 2'b11) || (n >= 4 && h == 4'b1001);
    endfunction

    task automatic check(input string req);
        n_checks++;
        if (detect !== exp_q) begin
            n_fail++;
            $display("FAIL %s: detect=%b expected=%b", req, detect, exp_q);
        end
    endtask

    // at a falling edge: check the current output, then drive the next bit
    task automatic step(input logic r, input logic b, input string req);
        @(negedge clk);
        check(req);
        rst = r;
        din = b;
        if (r) begin
            hist = 4'b0; seen = 0; found = 1'b0; exp_q = 1'b0;
        end else begin
            hist = {hist[2:0], b};
            if (seen < 4) seen++;
            exp_q = !found && marker(hist, seen);
            if (exp_q) found = 1'b1;
        end
    endtask

    task automatic stream(input logic [7:0] bits, input int len, input string req);
        step(1'b1, 1'b0, req);
        for (int i = len - 1; i >= 0; i--) step(1'b0, bits[i], req);
        step(1'b0, 1'b0, req);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1729));
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        stream(8'b0000_0011, 2, "R2");
        stream(8'b0000_1001, 4, "R3");
        stream(8'b0000_1011, 5, "R4");
        stream(8'b0000_1001, 4, "R4");
        stream(8'b0000_0010, 4, "R5");
        stream(8'b0001_0001, 5, "R6");
        // R7, R8: flag once, then ones keep arriving
        stream(8'b0000_0011, 2, "R7");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, "R8");
        // R1: reset mid-match clears history
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        // random streams with periodic resets
        for (int i = 0; i < 20000; i++) begin
            logic r;
            r = (($urandom % 23) == 0);
            step(r, 1'(($urandom % 3) != 0 ? $urandom % 2 : 0), "R2,R3");
        end
        step(1'b0, 1'b0, "R7");
        finish_run();
    end
endmodule